// File: doc/BRIEF.md
# Core-Local Timer and Software Interrupt Unit

This block gives each hart of a small multi-hart system two machine-level interrupt sources. One 64-bit time counter is shared by all harts. Each hart also has a 64-bit compare register and a one-bit software-interrupt flag. A hart's timer line is a level: it is high whenever that hart's compare value is at or below the current time. A hart's software line follows its flag, and any other hart can set or clear that flag with a plain register write, which makes it a doorbell between harts.

All access goes through a small 32-bit register port: a request strobe, a write enable, a byte address, write data and registered read data. Three address windows can be placed anywhere through parameters: the per-hart flag words, the per-hart compare pairs and the time pair. The hart count is also a parameter. The counter advances only on cycles in which the timebase tick enable is high, so a slow reference tick can pace it while the bus runs on the fast clock.

Top module: `hart_timer_irq`

## Requirements
- R1: After reset the time counter, every compare register and every software flag are 0. Because 0 <= 0, every bit of `timer_irq` is 1 and every bit of `soft_irq` is 0 while no register has been written.
- R2: The time counter adds one at each clock edge where `tick_en` is high and holds otherwise. A read at `TIME_BASE` returns bits 31:0 and a read at `TIME_BASE+4` returns bits 63:32, both as the counter stood before that edge.
- R3: A write to `TIME_BASE` or `TIME_BASE+4` leaves the counter unchanged.
- R4: The flag word of hart h sits at `SWI_BASE + 4*h`. A read returns 1 if the flag is set and 0 if not, and `soft_irq[h]` equals the flag.
- R5: A write to a flag word sets the flag when the write data is nonzero and clears it when the data is 0.
- R6: The compare register of hart h occupies `CMP_BASE + 8*h` (bits 31:0) and `CMP_BASE + 8*h + 4` (bits 63:32), and both words read back what was written.
- R7: A write to one half of a compare register changes that half only. The other half keeps its value.
- R8: `timer_irq[h]` is 1 exactly when compare(h) <= time. This covers three cases: a compare written at or below the time raises the line, a compare written above the time lowers it, and the line rises again on the cycle the counter reaches the compare value.
- R9: A read whose address has bit 1 or bit 0 set, or that falls in no window, returns 0. A write to such an address changes no register.
- R10: `rdata` carries the result one cycle after a read request and is 0 in the cycle after any cycle with no read request. A write takes effect at the clock edge of its request, and the outputs show the new state in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase tick; the counter advances on cycles where it is high |
| req | input | 1 | Register access request |
| wr_en | input | 1 | 1 for write, 0 for read, qualified by req |
| addr | input | ADDR_W | Byte address of the 32-bit word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after a read request |
| timer_irq | output | NUM_HARTS | Per-hart timer interrupt level |
| soft_irq | output | NUM_HARTS | Per-hart software interrupt level |

## Verification
The hardest case to reach from the ports is the moment the counter climbs up to a compare value that sits just above it. A compare value in the future only pays off if the bench knows the exact time when the write lands. The directed part uses the bench's own time model to write a compare a few ticks ahead. It then steps the tick one edge at a time and watches the line stay low and then rise on the exact cycle. The random part writes compare low halves within a few counts of the modelled time, so that both writes into the past and writes into the future happen often. It also writes halves one at a time, which produces transient values that must be judged on the whole 64-bit value.

// File: rtl/hti_pkg.sv
package hti_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned CNT_W  = 2 * WORD_W;

   typedef enum logic [1:0] {
      RG_NONE = 2'd0,
      RG_SWI  = 2'd1,
      RG_CMP  = 2'd2,
      RG_TIME = 2'd3
   } region_e;

   typedef struct packed {
      region_e region;
      logic    upper;
   } decode_t;
endpackage

// File: rtl/hti_decode.sv
module hti_decode
   import hti_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned NUM_HARTS = 3,
   parameter int unsigned HART_W    = 2,
   parameter int unsigned SWI_BASE  = 32'h0000,
   parameter int unsigned CMP_BASE  = 32'h4000,
   parameter int unsigned TIME_BASE = 32'hBFF8
) (
   input  logic [ADDR_W-1:0] addr,
   output decode_t           dec,
   output logic [HART_W-1:0] hart
);
   localparam logic [31:0] SWI_SPAN = 32'(NUM_HARTS * 4);
   localparam logic [31:0] CMP_SPAN = 32'(NUM_HARTS * 8);

   logic [31:0] a32;
   logic [31:0] swi_off;
   logic [31:0] cmp_off;
   logic        aligned;

   always_comb begin
      a32     = 32'(addr);
      swi_off = a32 - SWI_BASE;
      cmp_off = a32 - CMP_BASE;
      aligned = (a32[1:0] == 2'b00);
      dec     = '{region: RG_NONE, upper: 1'b0};
      hart    = '0;
      if (aligned && a32 >= SWI_BASE && swi_off < SWI_SPAN) begin
         dec.region = RG_SWI;
         hart       = HART_W'(swi_off >> 2);
      end else if (aligned && a32 >= CMP_BASE && cmp_off < CMP_SPAN) begin
         dec.region = RG_CMP;
         dec.upper  = cmp_off[2];
         hart       = HART_W'(cmp_off >> 3);
      end else if (a32 == TIME_BASE) begin
         dec.region = RG_TIME;
      end else if (a32 == TIME_BASE + 32'd4) begin
         dec.region = RG_TIME;
         dec.upper  = 1'b1;
      end
   end
endmodule

// File: rtl/hti_timebase.sv
module hti_timebase
   import hti_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n)       count <= '0;
      else if (tick_en) count <= count + 1'b1;
   end

   assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(count));
   assert_step_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> count != $past(count));
endmodule

// File: rtl/hti_hart_slot.sv
module hti_hart_slot
   import hti_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_we,
   input  logic              cmp_we_lo,
   input  logic              cmp_we_hi,
   input  logic [WORD_W-1:0] wdata,
   input  logic [CNT_W-1:0]  time_now,
   output logic [CNT_W-1:0]  cmp_q,
   output logic              soft_q,
   output logic              timer_irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q  <= '0;
         soft_q <= 1'b0;
      end else begin
         if (sw_we)     soft_q <= (wdata != '0);
         if (cmp_we_lo) cmp_q[WORD_W-1:0] <= wdata;
         if (cmp_we_hi) cmp_q[CNT_W-1:WORD_W] <= wdata;
      end
   end

   assign timer_irq = (cmp_q <= time_now);

   assert_sw_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sw_we && (wdata != '0) |=> soft_q);
   assert_sw_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sw_we && (wdata == '0) |=> !soft_q);
   assert_lo_keeps_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_we_lo && !cmp_we_hi |=> cmp_q[CNT_W-1:WORD_W] == $past(cmp_q[CNT_W-1:WORD_W]));
   assert_hi_keeps_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_we_hi && !cmp_we_lo |=> cmp_q[WORD_W-1:0] == $past(cmp_q[WORD_W-1:0]));
   assert_rise_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timer_irq) |-> ($past(cmp_we_lo || cmp_we_hi) || time_now != $past(time_now)));
endmodule

// File: rtl/hart_timer_irq.sv
module hart_timer_irq
   import hti_pkg::*;
#(
   parameter int unsigned NUM_HARTS = 3,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned SWI_BASE  = 32'h0000,
   parameter int unsigned CMP_BASE  = 32'h4000,
   parameter int unsigned TIME_BASE = 32'hBFF8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_en,
   input  logic                 req,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [WORD_W-1:0]    wdata,
   output logic [WORD_W-1:0]    rdata,
   output logic [NUM_HARTS-1:0] timer_irq,
   output logic [NUM_HARTS-1:0] soft_irq
);
   localparam int unsigned HART_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

   generate
      if (NUM_HARTS < 1 || NUM_HARTS > 64)
         $error("hart_timer_irq: NUM_HARTS must be 1..64");
      if (ADDR_W < 4 || ADDR_W > 32)
         $error("hart_timer_irq: ADDR_W must be 4..32");
      if ((SWI_BASE % 4) != 0 || (CMP_BASE % 8) != 0 || (TIME_BASE % 8) != 0)
         $error("hart_timer_irq: window bases misaligned");
      if (SWI_BASE + 4 * NUM_HARTS > CMP_BASE || CMP_BASE + 8 * NUM_HARTS > TIME_BASE)
         $error("hart_timer_irq: windows overlap or are out of order");
      if ((64'(TIME_BASE) + 64'd8) > (64'd1 << ADDR_W))
         $error("hart_timer_irq: time window beyond address space");
   endgenerate

   decode_t           dec;
   logic [HART_W-1:0] hart;
   logic [CNT_W-1:0]  time_now;
   logic [CNT_W-1:0]  cmp_arr [NUM_HARTS];
   logic              wr_go;
   logic              rd_go;
   logic [WORD_W-1:0] rd_word;

   assign wr_go = req && wr_en;
   assign rd_go = req && !wr_en;

   hti_decode #(
      .ADDR_W(ADDR_W), .NUM_HARTS(NUM_HARTS), .HART_W(HART_W),
      .SWI_BASE(SWI_BASE), .CMP_BASE(CMP_BASE), .TIME_BASE(TIME_BASE)
   ) u_decode (
      .addr(addr), .dec(dec), .hart(hart)
   );

   hti_timebase u_timebase (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count(time_now)
   );

   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
      logic sel;
      assign sel = wr_go && (hart == HART_W'(h));
      hti_hart_slot u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .sw_we     (sel && dec.region == RG_SWI),
         .cmp_we_lo (sel && dec.region == RG_CMP && !dec.upper),
         .cmp_we_hi (sel && dec.region == RG_CMP &&  dec.upper),
         .wdata     (wdata),
         .time_now  (time_now),
         .cmp_q     (cmp_arr[h]),
         .soft_q    (soft_irq[h]),
         .timer_irq (timer_irq[h])
      );
   end

   always_comb begin
      rd_word = '0;
      case (dec.region)
         RG_SWI:  rd_word = WORD_W'(soft_irq[hart]);
         RG_CMP:  rd_word = dec.upper ? cmp_arr[hart][CNT_W-1:WORD_W]
                                      : cmp_arr[hart][WORD_W-1:0];
         RG_TIME: rd_word = dec.upper ? time_now[CNT_W-1:WORD_W]
                                      : time_now[WORD_W-1:0];
         default: rd_word = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_go) rdata <= rd_word;
      else            rdata <= '0;
   end

   assert_idle_rdata_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_go |=> rdata == '0);
   assert_misaligned_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go && (addr[1:0] != 2'b00) |=> rdata == '0);
   assert_time_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_go && !tick_en && (32'(addr) == TIME_BASE || 32'(addr) == TIME_BASE + 32'd4)
      |=> $stable(time_now));
   assert_bad_write_no_soft_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_go && (addr[1:0] != 2'b00) |=> $stable(soft_irq));
endmodule

// File: tb/hart_timer_irq_test.sv
`timescale 1ns/1ps
module hart_timer_irq_test;
   localparam int unsigned NH = 3;
   localparam int unsigned AW = 16;
   localparam int unsigned SB = 32'h0000;
   localparam int unsigned CB = 32'h4000;
   localparam int unsigned TB = 32'hBFF8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic          req = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NH-1:0] timer_irq;
   logic [NH-1:0] soft_irq;

   always #10 clk = ~clk;

   hart_timer_irq #(.NUM_HARTS(NH), .ADDR_W(AW), .SWI_BASE(SB), .CMP_BASE(CB), .TIME_BASE(TB))
   uut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req(req), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .timer_irq(timer_irq), .soft_irq(soft_irq));

   logic [63:0] m_time;
   logic [63:0] m_cmp [NH];
   logic        m_sw  [NH];
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 0;

   // kind: 0 none, 1 flag, 2 compare, 3 time
   function automatic void bdec(input logic [AW-1:0] a, output int kind, output int h,
                                output bit up);
      int unsigned x = 32'(a);
      kind = 0; h = 0; up = 0;
      if (x % 4 == 0 && x >= SB && x < SB + 4 * NH) begin
         kind = 1; h = int'((x - SB) / 4);
      end else if (x % 4 == 0 && x >= CB && x < CB + 8 * NH) begin
         kind = 2; h = int'((x - CB) / 8); up = ((x - CB) % 8) == 4;
      end else if (x == TB) begin
         kind = 3;
      end else if (x == TB + 4) begin
         kind = 3; up = 1;
      end
   endfunction

   function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
      int k; int h; bit up;
      bdec(a, k, h, up);
      case (k)
         1: return {31'd0, m_sw[h]};
         2: return up ? m_cmp[h][63:32] : m_cmp[h][31:0];
         3: return up ? m_time[63:32] : m_time[31:0];
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic [NH-1:0] exp_timer();
      logic [NH-1:0] v;
      for (int h = 0; h < NH; h++) v[h] = (m_cmp[h] <= m_time);
      return v;
   endfunction

   function automatic logic [NH-1:0] exp_soft();
      logic [NH-1:0] v;
      for (int h = 0; h < NH; h++) v[h] = m_sw[h];
      return v;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one bus cycle; called at a falling edge, returns at the next falling edge
   task automatic cyc(input bit r, input bit w, input logic [AW-1:0] a,
                      input logic [31:0] d, input bit t, input string tag);
      logic [31:0] er;
      int k; int h; bit up;
      req = r; wr_en = w; addr = a; wdata = d; tick_en = t;
      er = (r && !w) ? exp_read(a) : 32'd0;
      @(posedge clk);
      if (r && w) begin
         bdec(a, k, h, up);
         if (k == 1) m_sw[h] = (d != 0);
         if (k == 2) begin
            if (up) m_cmp[h][63:32] = d; else m_cmp[h][31:0] = d;
         end
      end
      if (t) m_time = m_time + 1;
      @(negedge clk);
      req = 0; wr_en = 0; tick_en = 0;
      check({tag, " R10 rdata"}, 64'(rdata), 64'(er));
      check({tag, " R8 timer_irq"}, 64'(timer_irq), 64'(exp_timer()));
      check({tag, " R4 soft_irq"}, 64'(soft_irq), 64'(exp_soft()));
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
      cyc(1, 1, a, d, 0, tag);
   endtask
   task automatic rd(input logic [AW-1:0] a, input string tag);
      cyc(1, 0, a, 0, 0, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      m_time = 0;
      for (int h = 0; h < NH; h++) begin m_cmp[h] = 0; m_sw[h] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      check("R1 timer_irq after reset", 64'(timer_irq), 64'({NH{1'b1}}));
      check("R1 soft_irq after reset", 64'(soft_irq), 0);
      check("R1 rdata after reset", 64'(rdata), 0);
      rd(AW'(CB + 8 + 4), "R1 compare reset");
      rd(AW'(TB), "R2 time low at reset");
      // R2 ticks
      for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1, "R2 tick");
      cyc(0, 0, 0, 0, 0, "R2 hold");
      rd(AW'(TB), "R2 time low");
      rd(AW'(TB + 4), "R2 time high");
      // R4 R5 flags
      wr(AW'(SB + 4), 32'h5, "R5 set flag");
      rd(AW'(SB + 4), "R4 read flag");
      wr(AW'(SB + 8), 32'h8000_0000, "R5 set msb");
      wr(AW'(SB + 4), 32'h0, "R5 clear flag");
      rd(AW'(SB + 4), "R4 read cleared");
      // R6 R7 compare halves
      wr(AW'(CB), 32'd200, "R6 cmp0 lo");
      rd(AW'(CB), "R6 readback lo");
      wr(AW'(CB + 4), 32'h1, "R7 cmp0 hi");
      rd(AW'(CB), "R7 lo kept");
      wr(AW'(CB), 32'd3, "R7 lo rewrite");
      rd(AW'(CB + 4), "R7 hi kept");
      wr(AW'(CB + 4), 32'h0, "R8 cmp0 past");
      // R8 crossing
      wr(AW'(CB + 16), m_time[31:0] + 32'd4, "R8 cmp2 future");
      for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1, "R8 approach");
      wr(AW'(CB + 16), m_time[31:0], "R8 cmp equal time");
      // R3 time write ignored
      wr(AW'(TB), 32'hFFFF_FFFF, "R3 time lo write");
      wr(AW'(TB + 4), 32'h1234, "R3 time hi write");
      rd(AW'(TB), "R3 time lo kept");
      rd(AW'(TB + 4), "R3 time hi kept");
      // R9 bad addresses
      wr(AW'(SB + 4 + 1), 32'h1, "R9 misaligned flag write");
      rd(AW'(SB + 4), "R9 flag unchanged");
      rd(AW'(SB + 8 + 2), "R9 misaligned read");
      rd(AW'(CB + 1), "R9 misaligned cmp read");
      rd(AW'(32'h2000), "R9 unmapped read");
      wr(AW'(CB + 8 * NH), 32'h0, "R9 past last hart");
      rd(AW'(TB + 2), "R9 misaligned time");
      // random mix
      for (int i = 0; i < 1500; i++) begin
         int unsigned sel = $urandom % 10;
         int unsigned h = $urandom % (NH + 1);
         bit t = ($urandom % 3) != 0;
         bit w = $urandom % 2;
         logic [31:0] d;
         logic [AW-1:0] a;
         if (sel < 3) begin
            a = AW'(SB + 4 * h + (($urandom % 8) == 0 ? 1 : 0));
            d = ($urandom % 2) ? $urandom : 32'd0;
         end else if (sel < 7) begin
            bit up = ($urandom % 4) == 0;
            a = AW'(CB + 8 * h + (up ? 4 : 0));
            d = up ? (($urandom % 4 == 0) ? $urandom : 32'd0)
                   : m_time[31:0] + 32'($urandom % 16) - 32'd6;
         end else if (sel < 8) begin
            a = AW'(TB + 4 * ($urandom % 2));
            d = $urandom;
         end else begin
            a = AW'($urandom);
            d = $urandom;
         end
         cyc(($urandom % 4) != 0, w, a, d, t, "R8 random");
      end
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule